// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is a general-purpose I/O port with up to sixteen lines. A direction register sets each line on its own as an input or an output. The port keeps an output latch that sets the level to be driven, and an input latch that takes in the synchronised pad levels whenever a state-time strobe arrives. It also holds two per-line registers that control the internal pull devices. It drives output-enable, output level and pull controls to the pad ring.

Software reaches the port through a small address/write-enable/byte-enable bus. A read of the data register gives, for each line, one of two values. An input line returns its captured pin level. An output line returns its latch. Three extra write addresses do a set, clear or toggle in one operation. Each line takes its source from the same per-line view a read would return, and the result goes back into the output latch.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While reset is low and after it is released, every line is an input (pad_oe = 0), the output latch is 0 (pad_out = 0), pulls are disabled (pad_pull_en = 0, pad_pull_sel = 0) and the input latch is 0.
- R2: A write to address 0 loads bus_wdata into the output latch at the next clock edge. This happens for every enabled line, input or output, and pad_out shows the latch.
- R3: A write to address 1 sets the direction register (1 = output, 0 = input) at the next edge, and pad_oe equals the direction bit of each line.
- R4: Pad levels pass through two synchroniser flops. The input latch loads the second flop's value only on an edge where state_tick is 1, for every line whatever its direction, and holds otherwise.
- R5: A read of address 0 returns the output latch for lines whose direction bit is 1 and the input latch for lines whose direction bit is 0. bus_rdata follows bus_addr in the same cycle.
- R6: Writes to address 4 (set: view OR data), 5 (clear: view AND NOT data) and 6 (toggle: view XOR data) form a result from the per-line read view of R5 and store it in the output latch at the next edge.
- R7: Addresses 2 and 3 hold pull-enable and pull-select (1 = pull-up, 0 = pull-down). pad_pull_en is the pull-enable bit gated off on output lines, and pad_pull_sel is the pull-select bit.
- R8: Reads of addresses 1, 2 and 3 return direction, pull-enable and pull-select. Reads of addresses 4 to 7 return 0. A write to address 7 changes nothing.
- R9: bus_be bit k covers lines 8k to 8k+7. Lines in a byte whose enable is 0 keep their value on every write, including set, clear and toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_tick | input | 1 | Strobe that lets the input latch sample |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NUM_LINES | Write data |
| bus_be | input | BE_W | Byte enables, one per eight lines |
| bus_rdata | output | NUM_LINES | Read data for bus_addr |
| pad_in | input | NUM_LINES | Pad levels from the pad ring |
| pad_out | output | NUM_LINES | Output latch to the pads |
| pad_oe | output | NUM_LINES | Per-line driver enable |
| pad_pull_en | output | NUM_LINES | Per-line pull device enable |
| pad_pull_sel | output | NUM_LINES | Per-line pull polarity, 1 = up |

## Verification
The direction register is loaded with a split pattern: one byte of outputs and one of inputs. The pins are then driven against the latch values, so a data read shows whether each line takes its value from the pin or from the latch. Pin changes are made while state_tick is held low and then with the strobe pulsed. This separates the synchroniser delay from the hold behaviour of the input latch. Set, clear and toggle run on mixed directions with partial byte enables, which shows whether the modify source follows direction and whether disabled bytes are left alone. A long stretch of random bus traffic, pin levels and strobes is then compared every cycle against a behavioural model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_DATA  = 3'd0,
      REG_DIR   = 3'd1,
      REG_PEN   = 3'd2,
      REG_PSEL  = 3'd3,
      REG_SET   = 3'd4,
      REG_CLR   = 3'd5,
      REG_TGL   = 3'd6,
      REG_NONE  = 3'd7
   } gpio_reg_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] pins,
   output logic [W-1:0] in_lat
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= pins;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    in_lat <= '0;
      else if (tick) in_lat <= stg[STAGES-1];
endmodule

// File: rtl/gpio_view.sv
module gpio_view
   import gpio_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      out_lat,
   input  logic [W-1:0]      in_lat,
   input  logic [W-1:0]      dir,
   input  logic [W-1:0]      pen,
   input  logic [W-1:0]      psel,
   output logic [W-1:0]      pin_view,
   output logic [W-1:0]      rdata
);
   always_comb begin
      for (int i = 0; i < W; i++)
         pin_view[i] = dir[i] ? out_lat[i] : in_lat[i];
   end

   always_comb begin
      unique case (gpio_reg_e'(addr))
         REG_DATA: rdata = pin_view;
         REG_DIR:  rdata = dir;
         REG_PEN:  rdata = pen;
         REG_PSEL: rdata = psel;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int W    = 16,
   parameter int BE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      wdata,
   input  logic [BE_W-1:0]   be,
   input  logic [W-1:0]      pin_view,
   output logic [W-1:0]      out_lat,
   output logic [W-1:0]      dir,
   output logic [W-1:0]      pen,
   output logic [W-1:0]      psel
);
   logic [W-1:0] lane_mask;
   logic [W-1:0] rmw_val;

   always_comb begin
      for (int i = 0; i < W; i++)
         lane_mask[i] = be[i/8];
   end

   always_comb begin
      unique case (gpio_reg_e'(addr))
         REG_SET: rmw_val = pin_view | wdata;
         REG_CLR: rmw_val = pin_view & ~wdata;
         REG_TGL: rmw_val = pin_view ^ wdata;
         default: rmw_val = wdata;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_lat <= '0;
         dir     <= '0;
         pen     <= '0;
         psel    <= '0;
      end else if (we) begin
         unique case (gpio_reg_e'(addr))
            REG_DATA, REG_SET, REG_CLR, REG_TGL:
               out_lat <= (out_lat & ~lane_mask) | (rmw_val & lane_mask);
            REG_DIR:  dir  <= (dir  & ~lane_mask) | (wdata & lane_mask);
            REG_PEN:  pen  <= (pen  & ~lane_mask) | (wdata & lane_mask);
            REG_PSEL: psel <= (psel & ~lane_mask) | (wdata & lane_mask);
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_pkg::*;
#(
   parameter int NUM_LINES   = 16,
   parameter int SYNC_STAGES = 2,
   localparam int BE_W       = (NUM_LINES + 7) / 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 state_tick,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [NUM_LINES-1:0] bus_wdata,
   input  logic [BE_W-1:0]      bus_be,
   output logic [NUM_LINES-1:0] bus_rdata,
   input  logic [NUM_LINES-1:0] pad_in,
   output logic [NUM_LINES-1:0] pad_out,
   output logic [NUM_LINES-1:0] pad_oe,
   output logic [NUM_LINES-1:0] pad_pull_en,
   output logic [NUM_LINES-1:0] pad_pull_sel
);
   if (NUM_LINES < 1 || NUM_LINES > 16) begin : g_bad_width
      $error("gpio_port_ctrl: NUM_LINES must lie in 1..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_port_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [NUM_LINES-1:0] in_lat;
   logic [NUM_LINES-1:0] out_lat;
   logic [NUM_LINES-1:0] dir;
   logic [NUM_LINES-1:0] pen;
   logic [NUM_LINES-1:0] psel;
   logic [NUM_LINES-1:0] pin_view;

   gpio_in_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (state_tick),
      .pins   (pad_in),
      .in_lat (in_lat)
   );

   gpio_view #(.W(NUM_LINES)) u_view (
      .addr     (bus_addr),
      .out_lat  (out_lat),
      .in_lat   (in_lat),
      .dir      (dir),
      .pen      (pen),
      .psel     (psel),
      .pin_view (pin_view),
      .rdata    (bus_rdata)
   );

   gpio_regs #(.W(NUM_LINES), .BE_W(BE_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (bus_we),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .be       (bus_be),
      .pin_view (pin_view),
      .out_lat  (out_lat),
      .dir      (dir),
      .pen      (pen),
      .psel     (psel)
   );

   assign pad_out      = out_lat;
   assign pad_oe       = dir;
   assign pad_pull_en  = pen & ~dir;
   assign pad_pull_sel = psel;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
   parameter int W    = 16,
   parameter int BE_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tick,
   input logic            we,
   input logic [2:0]      addr,
   input logic [W-1:0]    wdata,
   input logic [BE_W-1:0] be,
   input logic [W-1:0]    in_lat,
   input logic [W-1:0]    pad_out,
   input logic [W-1:0]    pad_oe,
   input logic [W-1:0]    pad_pull_en
);
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (pad_oe == '0 && pad_out == '0 && pad_pull_en == '0)
            else $error("R1 outputs active during reset");
      end
   end

   a_r2_data_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 3'd0 && &be) |=> (pad_out == $past(wdata)));

   a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 3'd1 && &be) |=> (pad_oe == $past(wdata)));

   a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(in_lat));

   a_r6_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 3'd4 && &be) |=> ((pad_out & $past(wdata)) == $past(wdata)));

   a_r6_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 3'd5 && &be) |=> ((pad_out & $past(wdata)) == '0));

   a_r7_pull_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && (addr == 3'd1 || addr == 3'd2)) |=> $stable(pad_pull_en));

   a_r9_no_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (we && be == '0) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.W(NUM_LINES), .BE_W(BE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (state_tick),
   .we          (bus_we),
   .addr        (bus_addr),
   .wdata       (bus_wdata),
   .be          (bus_be),
   .in_lat      (in_lat),
   .pad_out     (pad_out),
   .pad_oe      (pad_oe),
   .pad_pull_en (pad_pull_en)
);

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/1ps
module gpio_port_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        state_tick = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [15:0] bus_wdata = '0;
   logic [1:0]  bus_be = 2'b00;
   logic [15:0] bus_rdata;
   logic [15:0] pad_in = '0;
   logic [15:0] pad_out, pad_oe, pad_pull_en, pad_pull_sel;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit auto_tick = 0;
   int cyc = 0;

   gpio_port_ctrl uut (
      .clk(clk), .rst_n(rst_n), .state_tick(state_tick),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
      .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .pad_pull_en(pad_pull_en), .pad_pull_sel(pad_pull_sel)
   );

   always #2.5 clk = ~clk;

   // behavioural reference
   logic [15:0] m_out, m_dir, m_pen, m_psel, m_lat;
   logic [15:0] pin_hist[$];

   function automatic logic [15:0] m_view();
      return (m_dir & m_out) | (~m_dir & m_lat);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_out = '0; m_dir = '0; m_pen = '0; m_psel = '0; m_lat = '0;
         pin_hist = {16'h0, 16'h0};
      end else begin
         logic [15:0] mask, v, synced;
         mask = {{8{bus_be[1]}}, {8{bus_be[0]}}};
         v = m_view();
         synced = pin_hist.pop_front();
         pin_hist.push_back(pad_in);
         if (bus_we) begin
            case (bus_addr)
               3'd0: m_out = (m_out & ~mask) | (bus_wdata & mask);
               3'd1: m_dir = (m_dir & ~mask) | (bus_wdata & mask);
               3'd2: m_pen = (m_pen & ~mask) | (bus_wdata & mask);
               3'd3: m_psel = (m_psel & ~mask) | (bus_wdata & mask);
               3'd4: m_out = (m_out & ~mask) | ((v | bus_wdata) & mask);
               3'd5: m_out = (m_out & ~mask) | ((v & ~bus_wdata) & mask);
               3'd6: m_out = (m_out & ~mask) | ((v ^ bus_wdata) & mask);
               default: ;
            endcase
         end
         if (state_tick) m_lat = synced;
      end
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
      end
   endtask

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         logic [15:0] exp_rd;
         case (bus_addr)
            3'd0: exp_rd = m_view();
            3'd1: exp_rd = m_dir;
            3'd2: exp_rd = m_pen;
            3'd3: exp_rd = m_psel;
            default: exp_rd = '0;
         endcase
         chk("R2 R6 R9 pad_out", pad_out, m_out);
         chk("R3 pad_oe", pad_oe, m_dir);
         chk("R7 pad_pull_en", pad_pull_en, m_pen & ~m_dir);
         chk("R7 pad_pull_sel", pad_pull_sel, m_psel);
         chk("R4 R5 R8 bus_rdata", bus_rdata, exp_rd);
      end
   end

   always @(negedge clk) begin
      #0.5;
      if (auto_tick) state_tick <= (cyc % 3 == 0);
   end

   task automatic drv(input logic we, input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
      @(negedge clk); #0.6;
      bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drv(1'b0, bus_addr, '0, 2'b00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 pad_oe", pad_oe, 16'h0);
      chk("R1 pad_out", pad_out, 16'h0);
      chk("R1 pad_pull_en", pad_pull_en, 16'h0);
      chk("R1 pad_pull_sel", pad_pull_sel, 16'h0);
      chk("R1 rdata", bus_rdata, 16'h0);
      #0.6 rst_n = 1'b1;
      // R2: write to inputs lands in latch, not pad_oe
      drv(1'b1, 3'd0, 16'hA5C3, 2'b11);
      drv(1'b0, 3'd0, '0, 2'b00);
      chk("R2 latch on inputs", pad_out, 16'hA5C3);
      // R3 split directions
      drv(1'b1, 3'd1, 16'h00FF, 2'b11);
      // R4: pins change, no strobe -> input lines read old latch (0)
      pad_in = 16'h3C5A;
      drv(1'b0, 3'd0, '0, 2'b00);
      idle(4);
      chk("R4 hold without tick / R5 view", bus_rdata, 16'h00C3);
      state_tick = 1'b1;
      idle(1);
      state_tick = 1'b0;
      idle(1);
      chk("R4 sampled / R5 mixed view", bus_rdata, 16'h3CC3);
      // R6 set/clear/toggle on mixed directions, R9 partial lanes
      drv(1'b1, 3'd4, 16'h0101, 2'b11);
      drv(1'b1, 3'd5, 16'hFFFF, 2'b10);
      drv(1'b1, 3'd6, 16'hFFFF, 2'b01);
      drv(1'b1, 3'd0, 16'h1234, 2'b00);
      // R7 pulls on mixed directions
      drv(1'b1, 3'd2, 16'hF0F0, 2'b11);
      drv(1'b1, 3'd3, 16'h5555, 2'b11);
      drv(1'b0, 3'd2, '0, 2'b00);
      chk("R7 pull gated on outputs", pad_pull_en, 16'hF000);
      // R8 unmapped write and reads
      drv(1'b1, 3'd7, 16'hFFFF, 2'b11);
      drv(1'b0, 3'd5, '0, 2'b00);
      chk("R8 unmapped read", bus_rdata, 16'h0);
      // random traffic
      auto_tick = 1;
      for (int i = 0; i < 2000; i++) begin
         drv($urandom_range(0, 3) != 0, 3'($urandom_range(0, 7)), 16'($urandom), 2'($urandom_range(0, 3)));
         pad_in = 16'($urandom);
      end
      // reset mid-run: R1
      @(negedge clk); #0.6 rst_n = 1'b0;
      @(negedge clk);
      chk("R1 re-reset pad_out", pad_out, 16'h0);
      chk("R1 re-reset pad_oe", pad_oe, 16'h0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule